// File: doc/BRIEF.md
# Prioritized Reset Cause Arbiter

This block sits at the top of a chip's reset tree. Eight sources may ask for a reset: the power-on detector and seven synchronous requesters (external pin, software system, software external, watchdog, loss-of-lock, loss-of-clock and checkstop). When the block is idle and one or more synchronous requests are high at a clock edge, it picks one winner. From that edge it drives `reset_active` for a fixed number of cycles, pulses `reset_serviced` for one cycle and latches a one-hot record of the winner in `reset_cause`, which software reads after reset. The record stays until a later reset replaces it.

Winners are chosen by priority group. The external pin is highest. Software system reset is next. The clock, lock, watchdog and checkstop faults come after that, and the software external request is lowest. Within a group a fixed order makes the result unique. While a reset is running, further requests are dropped, not queued. There are two exceptions. Power-on is an asynchronous input that takes over at any time. A software external request that is newly raised restarts the sequence. All ports are plain control and status pins, so there is no stream handshake.

Top module: `reset_cause_arbiter`

## Requirements
- R1: While `por_req` is high, `reset_cause` reads 8'h01, `reset_active` reads 1 and `reset_serviced` reads 0, with no clock edge needed.
- R2: `reset_cause` is one-hot and uses a fixed bit map: bit 0 power-on, then `sys_req[i]` maps to status bit i+1 (`sys_req` bits: 0 external, 1 software system, 2 software external, 3 watchdog, 4 loss-of-lock, 5 loss-of-clock, 6 checkstop).
- R3: Simultaneous idle requests are resolved by group, highest first: external, then software system, then {watchdog, loss-of-lock, loss-of-clock, checkstop}, then software external.
- R4: Inside the fault group the order is watchdog, loss-of-lock, loss-of-clock, checkstop.
- R5: Requests are sampled at a clock edge. After that edge `reset_cause` holds the winner and `reset_serviced` is high for exactly one cycle.
- R6: `reset_active` stays high for exactly RESET_CYCLES cycles after a servicing edge, and for RESET_CYCLES cycles after `por_req` falls.
- R7: `reset_cause` does not change between servicing events.
- R8: A request other than a new software external request is dropped while `reset_active` is high. It leaves no trace once the reset ends.
- R9: A request still held when `reset_active` falls is serviced at the next clock edge.
- R10: A software external request that rises while `reset_active` is high is serviced at once and restarts the RESET_CYCLES count. A request that stays high does not preempt again. A request already high during power-on does not count as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| sys_req | input | 7 | Synchronous reset requests, bit map in R2 |
| reset_active | output | 1 | Internal reset sequence in progress |
| reset_serviced | output | 1 | One-cycle pulse after a winner is chosen |
| reset_cause | output | 8 | One-hot cause of the most recent reset |

## Verification
The assertions assume that `por_req` is asserted before the first clock edge and is held across several edges. They also assume that `sys_req` changes only between edges and is never unknown after power-on. The bench asserts `por_req` at time zero and raises and lowers it on falling edges, or between edges when it tests the asynchronous path. It drives `sys_req` only on falling edges, so every request is seen whole at exactly one rising edge.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
  localparam int NUM_SYS  = 7;
  localparam int STATUS_W = NUM_SYS + 1;

  // synchronous request indices
  localparam int SRC_EXT   = 0;
  localparam int SRC_SWSYS = 1;
  localparam int SRC_SWEXT = 2;
  localparam int SRC_WDOG  = 3;
  localparam int SRC_LOL   = 4;
  localparam int SRC_LOC   = 5;
  localparam int SRC_CHK   = 6;

  // service order, highest first
  localparam int PRIO_ORDER [NUM_SYS] = '{SRC_EXT, SRC_SWSYS, SRC_WDOG, SRC_LOL,
                                          SRC_LOC, SRC_CHK, SRC_SWEXT};

  typedef logic [NUM_SYS-1:0]  sys_vec_t;
  typedef logic [STATUS_W-1:0] cause_vec_t;

  localparam cause_vec_t CAUSE_POR = cause_vec_t'(1);
endpackage

// File: rtl/reset_prio_pick.sv
module reset_prio_pick
  import reset_cause_pkg::*;
(
  input  sys_vec_t req,
  output sys_vec_t win
);
  logic [NUM_SYS:0] taken;

  assign taken[0] = 1'b0;

  for (genvar k = 0; k < NUM_SYS; k++) begin : g_rank
    localparam int IDX = PRIO_ORDER[k];
    assign win[IDX]    = req[IDX] & ~taken[k];
    assign taken[k+1]  = taken[k] | req[IDX];
  end
endmodule

// File: rtl/reset_hold_timer.sv
module reset_hold_timer #(
  parameter int unsigned RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic por_req,
  input  logic load,
  output logic active
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      active <= 1'b1;
      remain <= CNT_W'(RESET_CYCLES);
    end else if (load) begin
      active <= 1'b1;
      remain <= CNT_W'(RESET_CYCLES);
    end else if (active) begin
      if (remain == CNT_W'(1)) begin
        active <= 1'b0;
      end else begin
        remain <= remain - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import reset_cause_pkg::*;
(
  input  logic       clk,
  input  logic       por_req,
  input  logic       grant,
  input  sys_vec_t   winner,
  output cause_vec_t cause,
  output logic       serviced
);
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      cause    <= CAUSE_POR;
      serviced <= 1'b0;
    end else begin
      serviced <= grant;
      if (grant) begin
        cause <= {winner, 1'b0};
      end
    end
  end
endmodule

// File: rtl/reset_cause_arbiter.sv
module reset_cause_arbiter
  import reset_cause_pkg::*;
#(
  parameter int unsigned RESET_CYCLES = 16
) (
  input  logic                clk,
  input  logic                por_req,
  input  logic [NUM_SYS-1:0]  sys_req,
  output logic                reset_active,
  output logic                reset_serviced,
  output logic [STATUS_W-1:0] reset_cause
);
  logic     swext_q;
  logic     swext_rise;
  sys_vec_t eligible;
  sys_vec_t winner;
  logic     grant;

  // a request held through power-on is not treated as new
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) swext_q <= 1'b1;
    else         swext_q <= sys_req[SRC_SWEXT];
  end

  assign swext_rise = sys_req[SRC_SWEXT] & ~swext_q;

  always_comb begin
    eligible = '0;
    if (!reset_active) begin
      eligible = sys_req;
    end else if (swext_rise) begin
      eligible[SRC_SWEXT] = 1'b1;
    end
  end

  reset_prio_pick u_pick (
    .req (eligible),
    .win (winner)
  );

  assign grant = |winner;

  reset_hold_timer #(.RESET_CYCLES(RESET_CYCLES)) u_timer (
    .clk     (clk),
    .por_req (por_req),
    .load    (grant),
    .active  (reset_active)
  );

  reset_cause_reg u_cause (
    .clk      (clk),
    .por_req  (por_req),
    .grant    (grant),
    .winner   (winner),
    .cause    (reset_cause),
    .serviced (reset_serviced)
  );
endmodule

// File: rtl/reset_cause_arbiter_chk.sv
module reset_cause_arbiter_chk
  import reset_cause_pkg::*;
#(
  parameter int unsigned RESET_CYCLES = 16
) (
  input logic                clk,
  input logic                por_req,
  input logic [NUM_SYS-1:0]  sys_req,
  input logic                reset_active,
  input logic                reset_serviced,
  input logic [STATUS_W-1:0] reset_cause
);
  localparam int WIN_W = $clog2(RESET_CYCLES + 2);

  logic [WIN_W-1:0] win_cnt;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)             win_cnt <= '0;
    else if (reset_serviced) win_cnt <= WIN_W'(1);
    else if (reset_active)   win_cnt <= win_cnt + WIN_W'(1);
    else                     win_cnt <= '0;
  end

  // R2
  cause_onehot_chk: assert property (@(posedge clk) disable iff (por_req)
    $countones(reset_cause) == 1);

  // R5
  pulse_in_reset_chk: assert property (@(posedge clk) disable iff (por_req)
    reset_serviced |-> reset_active);

  // R7
  cause_sticky_chk: assert property (@(posedge clk) disable iff (por_req)
    !reset_serviced |-> $stable(reset_cause));

  // R8
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (por_req)
    reset_active && !sys_req[SRC_SWEXT] |=> !reset_serviced);

  // R3
  ext_wins_chk: assert property (@(posedge clk) disable iff (por_req)
    !reset_active && sys_req[SRC_EXT] |=> reset_cause == STATUS_W'(2));

  // R6
  hold_window_chk: assert property (@(posedge clk) disable iff (por_req)
    reset_active && !reset_serviced |-> win_cnt < WIN_W'(RESET_CYCLES));
endmodule

bind reset_cause_arbiter reset_cause_arbiter_chk #(.RESET_CYCLES(RESET_CYCLES)) u_chk (.*);

// File: tb/tb_reset_cause_arbiter.sv
`timescale 1ns/1ps
module tb_reset_cause_arbiter;
  localparam int LEN = 16;

  logic       clk = 1'b0;
  logic       por_req;
  logic [6:0] sys_req;
  logic       reset_active;
  logic       reset_serviced;
  logic [7:0] reset_cause;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  reset_cause_arbiter #(.RESET_CYCLES(LEN)) dut (
    .clk            (clk),
    .por_req        (por_req),
    .sys_req        (sys_req),
    .reset_active   (reset_active),
    .reset_serviced (reset_serviced),
    .reset_cause    (reset_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic measure_active(output int n);
    n = 0;
    while (reset_active === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // called at a falling edge while idle
  task automatic serve(input logic [6:0] req, input logic [7:0] exp, input string tag);
    int n;
    sys_req = req;
    @(negedge clk);
    chk({tag, " cause"}, reset_cause, exp);
    chk({tag, " pulse R5"}, reset_serviced, 1);
    sys_req = '0;
    measure_active(n);
    chk({tag, " length R6"}, n, LEN);
  endtask

  task automatic t_por_reset();
    int n;
    #1;
    chk("R1 cause at por", reset_cause, 8'h01);
    chk("R1 active at por", reset_active, 1);
    chk("R1 pulse at por", reset_serviced, 0);
    repeat (3) @(negedge clk);
    chk("R1 cause held por", reset_cause, 8'h01);
    por_req = 1'b0;
    measure_active(n);
    chk("R6 length after por", n, LEN);
    chk("R7 cause after por", reset_cause, 8'h01);
  endtask

  task automatic t_single();
    for (int i = 0; i < 7; i++) begin
      serve(7'(1 << i), 8'(1 << (i + 1)), "R2 single");
    end
  endtask

  task automatic t_priority();
    serve(7'h7f, 8'h02, "R3 all");
    serve(7'h7e, 8'h04, "R3 swsys over faults");
    serve(7'h7c, 8'h10, "R3 wdog over swext");
    serve(7'h44, 8'h80, "R3 chk over swext");
    serve(7'h70, 8'h20, "R4 lol first");
    serve(7'h60, 8'h40, "R4 loc over chk");
  endtask

  task automatic t_pulse();
    int n;
    sys_req = 7'h08;
    @(negedge clk);
    chk("R5 pulse high", reset_serviced, 1);
    sys_req = '0;
    @(negedge clk);
    chk("R5 pulse low", reset_serviced, 0);
    chk("R5 still active", reset_active, 1);
    measure_active(n);
    chk("R6 remaining", n, LEN - 1);
  endtask

  task automatic t_drop();
    int n;
    sys_req = 7'h40;
    @(negedge clk);
    sys_req = '0;
    repeat (2) @(negedge clk);
    sys_req = 7'h0b;
    @(negedge clk);
    chk("R8 no pulse busy", reset_serviced, 0);
    chk("R8 cause kept busy", reset_cause, 8'h80);
    sys_req = '0;
    measure_active(n);
    chk("R8 length unchanged", n, LEN - 3);
    @(negedge clk);
    chk("R8 not queued pulse", reset_serviced, 0);
    chk("R8 not queued active", reset_active, 0);
    chk("R7 cause after drop", reset_cause, 8'h80);
  endtask

  task automatic t_held();
    int n;
    sys_req = 7'h40;
    @(negedge clk);
    chk("R9 first cause", reset_cause, 8'h80);
    sys_req = 7'h20;
    measure_active(n);
    chk("R9 first length", n, LEN);
    @(negedge clk);
    chk("R9 held served pulse", reset_serviced, 1);
    chk("R9 held served cause", reset_cause, 8'h40);
    sys_req = '0;
    measure_active(n);
    chk("R9 second length", n, LEN);
  endtask

  task automatic t_preempt();
    int n;
    sys_req = 7'h08;
    @(negedge clk);
    sys_req = '0;
    repeat (4) @(negedge clk);
    sys_req = 7'h04;
    @(negedge clk);
    chk("R10 preempt cause", reset_cause, 8'h08);
    chk("R10 preempt pulse", reset_serviced, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held no repeat", reset_serviced, 0);
    end
    sys_req = '0;
    measure_active(n);
    chk("R10 restarted length", n, LEN - 3);
  endtask

  task automatic t_por_mid();
    int n;
    sys_req = 7'h08;
    @(negedge clk);
    sys_req = '0;
    @(negedge clk);
    #5;
    por_req = 1'b1;
    sys_req = 7'h04;
    #1;
    chk("R1 async cause", reset_cause, 8'h01);
    chk("R1 async active", reset_active, 1);
    chk("R1 async pulse", reset_serviced, 0);
    repeat (3) @(negedge clk);
    por_req = 1'b0;
    @(negedge clk);
    chk("R10 por-held not new", reset_serviced, 0);
    chk("R10 por cause kept", reset_cause, 8'h01);
    sys_req = '0;
    @(negedge clk);
    measure_active(n);
    chk("R6 length after mid por", n, LEN - 2);
    chk("R7 por cause idle", reset_cause, 8'h01);
  endtask

  initial begin
    por_req = 1'b1;
    sys_req = '0;
    t_por_reset();
    t_single();
    t_priority();
    t_pulse();
    t_drop();
    t_held();
    t_preempt();
    t_por_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule